// File: doc/BRIEF.md
# Divide Operand Preparation Unit

This execution unit sets up a two-word register pair ahead of an iterative division sequence. It takes a dividend and a divisor, an operation select, the value that the upper destination register held before the operation, and one bit that picks between the older and newer revision of the overflow rules. From these it produces the low and high result words, and it updates the overflow, sticky-overflow and advance-overflow flag words.

Four preparations are supported. Signed word and unsigned word preparation extend the dividend into the upper word, by sign and by zero respectively. Unsigned byte and unsigned halfword preparation shift the dividend across the pair, so that later steps only need to produce an 8-bit or a 16-bit quotient. Every result is registered on the clock edge where the valid strobe is high. The sticky flag is held inside the unit and accumulates overflows until reset.

Top module: `divprep_unit`

## Requirements
- R1: A synchronous active-high reset clears lo_o, hi_o, v_o, sv_o and av_o to zero by the next clock edge.
- R2: With op_i = 0 (signed word), lo_o becomes the dividend and hi_o becomes 32 copies of dividend bit 31.
- R3: With op_i = 0, overflow is set when the divisor is 0, or when the divisor is 0xFFFFFFFF and the dividend is 0x80000000; in all other cases it is clear.
- R4: With op_i = 1 (unsigned word), lo_o becomes the dividend, hi_o becomes 0, and overflow is set only when the divisor is 0.
- R5: With op_i = 2 (unsigned byte), hi_o becomes the dividend shifted right logically by 8 and lo_o becomes the dividend shifted left by 24.
- R6: With op_i = 3 (unsigned halfword), hi_o becomes the dividend shifted right logically by 16 and lo_o becomes the dividend shifted left by 16.
- R7: With op_i = 2 or 3 and rev_new_i = 0, overflow is set when the magnitude of hi_prev_i is greater than or equal to the magnitude of the divisor. Both are read as two's-complement values, and their magnitudes are compared as unsigned numbers (0x80000000 has magnitude 2^31). hi_prev_i is taken as presented with the strobe, not from hi_o.
- R8: With op_i = 2 or 3 and rev_new_i = 1, overflow is set only when the divisor is 0.
- R9: The overflow result is placed in bit 31 of v_o, and bits 30 down to 0 of v_o are always zero.
- R10: On each strobe, bit 31 of sv_o becomes its old value ORed with the new overflow. Once set, it stays set until reset, and its other bits are zero.
- R11: av_o is zero after reset and after every operation.
- R12: When valid_i is low, lo_o, hi_o, v_o and sv_o keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Preparation select: 0 signed word, 1 unsigned word, 2 unsigned byte, 3 unsigned halfword |
| rev_new_i | input | 1 | 1 selects the newer overflow rule for byte and halfword forms |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| hi_prev_i | input | 32 | Prior contents of the upper destination register |
| lo_o | output | 32 | Low result word |
| hi_o | output | 32 | High result word |
| v_o | output | 32 | Overflow flag word, bit 31 only |
| sv_o | output | 32 | Sticky overflow flag word, bit 31 only |
| av_o | output | 32 | Advance-overflow flag word, always cleared |

## Verification
The checker assumes that the operands and the select are stable and known during the cycle in which valid_i is high. It relates results only to the inputs sampled at that edge, and it does not depend on what the inputs do while the strobe is low. The stimulus drives all inputs half a period before each edge. During idle cycles it changes the operands on purpose, to show that they are ignored. It also reaches each overflow boundary from both sides: the minimum-integer case, equal magnitudes, and a 0x80000000 prior upper word.

// File: rtl/divprep_pkg.sv
package divprep_pkg;

    typedef enum logic [1:0] {
        PREP_SWORD = 2'd0,
        PREP_UWORD = 2'd1,
        PREP_UBYTE = 2'd2,
        PREP_UHALF = 2'd3
    } prep_op_e;

endpackage

// File: rtl/divprep_shift.sv
module divprep_shift
    import divprep_pkg::*;
#(
    parameter int W = 32
) (
    input  prep_op_e       op,
    input  logic [W-1:0]   dividend,
    output logic [W-1:0]   lo,
    output logic [W-1:0]   hi
);
    localparam int BYTE_SH = W / 4;
    localparam int HALF_SH = W / 2;

    always_comb begin
        unique case (op)
            PREP_SWORD: begin
                lo = dividend;
                hi = {W{dividend[W-1]}};
            end
            PREP_UWORD: begin
                lo = dividend;
                hi = '0;
            end
            PREP_UBYTE: begin
                lo = dividend << (W - BYTE_SH);
                hi = dividend >> BYTE_SH;
            end
            default: begin
                lo = dividend << HALF_SH;
                hi = dividend >> HALF_SH;
            end
        endcase
    end
endmodule

// File: rtl/divprep_ovf.sv
module divprep_ovf
    import divprep_pkg::*;
#(
    parameter int W = 32
) (
    input  prep_op_e       op,
    input  logic           rev_new,
    input  logic [W-1:0]   dividend,
    input  logic [W-1:0]   divisor,
    input  logic [W-1:0]   hi_prev,
    output logic           ovf
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic           div_zero;
    logic           min_by_neg1;
    logic [W-1:0]   mag_prev;
    logic [W-1:0]   mag_div;

    always_comb begin
        div_zero    = (divisor == '0);
        min_by_neg1 = (divisor == '1) && (dividend == MIN_NEG);
        mag_prev    = hi_prev[W-1] ? (~hi_prev + 1'b1) : hi_prev;
        mag_div     = divisor[W-1] ? (~divisor + 1'b1) : divisor;
        unique case (op)
            PREP_SWORD: ovf = div_zero || min_by_neg1;
            PREP_UWORD: ovf = div_zero;
            default:    ovf = rev_new ? div_zero : (mag_prev >= mag_div);
        endcase
    end
endmodule

// File: rtl/divprep_unit.sv
module divprep_unit
    import divprep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid_i,
    input  logic [1:0]     op_i,
    input  logic           rev_new_i,
    input  logic [W-1:0]   dividend_i,
    input  logic [W-1:0]   divisor_i,
    input  logic [W-1:0]   hi_prev_i,
    output logic [W-1:0]   lo_o,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   v_o,
    output logic [W-1:0]   sv_o,
    output logic [W-1:0]   av_o
);
    typedef struct packed {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
        logic         v;
        logic         sv;
    } prep_state_t;

    prep_op_e      op_sel;
    logic [W-1:0]  lo_calc;
    logic [W-1:0]  hi_calc;
    logic          ovf_calc;
    prep_state_t   st_d;
    prep_state_t   st_q;

    assign op_sel = prep_op_e'(op_i);

    divprep_shift #(.W(W)) u_shift (
        .op       (op_sel),
        .dividend (dividend_i),
        .lo       (lo_calc),
        .hi       (hi_calc)
    );

    divprep_ovf #(.W(W)) u_ovf (
        .op       (op_sel),
        .rev_new  (rev_new_i),
        .dividend (dividend_i),
        .divisor  (divisor_i),
        .hi_prev  (hi_prev_i),
        .ovf      (ovf_calc)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            st_d.lo = lo_calc;
            st_d.hi = hi_calc;
            st_d.v  = ovf_calc;
            st_d.sv = st_q.sv | ovf_calc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lo_o = st_q.lo;
    assign hi_o = st_q.hi;
    assign v_o  = {st_q.v,  {(W-1){1'b0}}};
    assign sv_o = {st_q.sv, {(W-1){1'b0}}};
    assign av_o = '0;
endmodule

// File: rtl/divprep_chk.sv
module divprep_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           valid_i,
    input logic [1:0]     op_i,
    input logic [W-1:0]   dividend_i,
    input logic [W-1:0]   divisor_i,
    input logic [W-1:0]   lo_o,
    input logic [W-1:0]   hi_o,
    input logic [W-1:0]   v_o,
    input logic [W-1:0]   sv_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (lo_o == '0 && hi_o == '0 && sv_o == '0));

    // R2
    sword_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'd0) |=> (hi_o == {W{$past(dividend_i[W-1])}}));

    // R4
    uword_res_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'd1) |=> (hi_o == '0 && lo_o == $past(dividend_i)));

    // R4
    zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && divisor_i == '0) |=> v_o[W-1]);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        v_o[W-2:0] == '0);

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sv_o[W-1] |=> sv_o[W-1]);

    // R10
    sticky_cover_chk: assert property (@(posedge clk) disable iff (rst)
        v_o[W-1] |-> sv_o[W-1]);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(lo_o) && $stable(hi_o) && $stable(v_o) && $stable(sv_o)));
endmodule

bind divprep_unit divprep_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .op_i       (op_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .lo_o       (lo_o),
    .hi_o       (hi_o),
    .v_o        (v_o),
    .sv_o       (sv_o)
);

// File: tb/divprep_unit_bench.sv
module divprep_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic        rev_new_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic [31:0] hi_prev_i = '0;
    logic [31:0] lo_o, hi_o, v_o, sv_o, av_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] e_lo = '0, e_hi = '0, e_v = '0, e_sv = '0;
    string t_res = "R1";
    string t_ovf = "R1";

    always #5 clk = ~clk;

    divprep_unit u_divprep_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .rev_new_i(rev_new_i), .dividend_i(dividend_i), .divisor_i(divisor_i),
        .hi_prev_i(hi_prev_i), .lo_o(lo_o), .hi_o(hi_o), .v_o(v_o),
        .sv_o(sv_o), .av_o(av_o)
    );

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    function automatic longint mag(logic [31:0] x);
        longint s = longint'(signed'(x));
        return (s < 0) ? -s : s;
    endfunction

    task automatic compare_all();
        cmp(t_res, "lo", lo_o, e_lo);
        cmp(t_res, "hi", hi_o, e_hi);
        cmp(t_ovf, "v", v_o, e_v);
        cmp("R9", "v low bits", v_o & 32'h7fffffff, 32'h0);
        cmp("R10", "sv", sv_o, e_sv);
        cmp("R11", "av", av_o, 32'h0);
    endtask

    // Compare outputs, then drive the next stimulus and advance the model.
    task automatic step(bit vld, bit [1:0] op, bit rev, logic [31:0] a,
                        logic [31:0] b, logic [31:0] hp);
        bit ov;
        @(negedge clk);
        compare_all();
        rst = 1'b0; valid_i = vld; op_i = op; rev_new_i = rev;
        dividend_i = a; divisor_i = b; hi_prev_i = hp;
        if (!vld) begin
            t_res = "R12"; t_ovf = "R12";
            return;
        end
        case (op)
            2'd0: begin
                e_lo = a; e_hi = a[31] ? 32'hffffffff : 32'h0;
                ov = (b == 0) || (b == 32'hffffffff && a == 32'h80000000);
                t_res = "R2"; t_ovf = "R3";
            end
            2'd1: begin
                e_lo = a; e_hi = 0; ov = (b == 0);
                t_res = "R4"; t_ovf = "R4";
            end
            default: begin
                if (op == 2'd2) begin
                    e_hi = a / 256; e_lo = {a[7:0], 24'h0}; t_res = "R5";
                end else begin
                    e_hi = a / 65536; e_lo = {a[15:0], 16'h0}; t_res = "R6";
                end
                if (rev) begin ov = (b == 0); t_ovf = "R8"; end
                else begin ov = mag(hp) >= mag(b); t_ovf = "R7"; end
            end
        endcase
        e_v = ov ? 32'h80000000 : 32'h0;
        if (ov) e_sv = 32'h80000000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        compare_all();
        rst = 1'b1; valid_i = 1'b0;
        e_lo = 0; e_hi = 0; e_v = 0; e_sv = 0; t_res = "R1"; t_ovf = "R1";
    endtask

    initial begin
        do_reset();
        do_reset();
        // signed word, no overflow
        step(1, 0, 0, 32'h12345678, 32'd3, 32'h0);
        step(1, 0, 0, 32'h80000001, 32'd5, 32'h0);
        step(1, 0, 0, 32'h80000000, 32'hfffffffe, 32'h0);
        // idle: operands change, outputs must hold
        step(0, 1, 1, 32'hdeadbeef, 32'h0, 32'h0);
        step(0, 2, 0, 32'h0badf00d, 32'h0, 32'hffffffff);
        // unsigned word
        step(1, 1, 0, 32'hfedcba98, 32'd7, 32'h0);
        // byte, old revision
        step(1, 2, 0, 32'haabbccdd, 32'd6, 32'd5);
        step(1, 2, 0, 32'haabbccdd, 32'hfffffffa, 32'd5);
        // halfword, newer revision
        step(1, 3, 1, 32'h12345678, 32'd3, 32'h7fffffff);
        // first overflow: old rule, equal magnitudes, prior upper reg negative
        step(1, 2, 0, 32'h01020304, 32'd6, 32'hfffffffa);
        step(1, 3, 0, 32'h0000ffff, 32'h7fffffff, 32'h80000000);
        step(1, 1, 0, 32'h00000010, 32'd9, 32'h0);
        step(0, 0, 0, 32'h1, 32'h1, 32'h1);
        step(1, 0, 0, 32'h80000000, 32'hffffffff, 32'h0);
        step(1, 0, 1, 32'h00000042, 32'h0, 32'h0);
        step(1, 1, 0, 32'h00000042, 32'h0, 32'h0);
        step(1, 3, 1, 32'h00ff00ff, 32'h0, 32'h0);
        step(1, 2, 1, 32'h00ff00ff, 32'd2, 32'h7fffffff);
        // reset in mid-run clears the sticky flag
        do_reset();
        step(1, 3, 0, 32'hcafef00d, 32'd100, 32'd99);
        step(1, 2, 0, 32'hcafef00d, 32'h80000000, 32'h80000000);
        step(0, 0, 0, 32'h0, 32'h0, 32'h0);
        step(0, 0, 0, 32'h0, 32'h0, 32'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule